// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps a sixteen-entry byte store for a multiplexed digit display and refreshes that display without stopping. The scan index moves on to the next digit every `SCAN_DIV` clocks. The scan index is presented in binary on `scan_o`. The byte stored at that index drives two 4-bit output groups: `out_a_o` carries the high half and `out_b_o` carries the low half. A two-bit mode input sets the digit count to 8 or 16. The same input selects how new characters enter the display: they either land at a host-set position or come in at the right edge and push the older digits one place left.

The host loads a position with `ptr_load_i` and writes bytes with `wr_i`. In left entry the position can step forward on each write. Each output half can be replaced by a shared blank code. A blank-display strobe marks every digit change so that the external drivers can avoid ghosting.

Top module: `disp_refresh`

## Requirements
- R1: While reset is held and right after it, every stored byte is 0, the write position is 0, `scan_o` is 0, both output groups are 0 and `bd_o` is 0.
- R2: In left entry (`mode_i[1]`=0), `ptr_load_i` sets the write position to `addr_i`, and a write stores `wr_data_i` at the current position.
- R3: In left entry with `auto_inc_i`=1, each write advances the position by one. After the last active digit (7 when `mode_i[0]`=0, 15 when it is 1), or from any higher position, the position returns to 0.
- R4: In left entry with `auto_inc_i`=0 the position holds, so repeated writes replace the same digit.
- R5: In right entry (`mode_i[1]`=1), a write places the byte at the last active digit and moves digits 1..last to 0..last-1. The old digit 0 is lost and the write position is unchanged. In 8-digit mode, digits 8..15 are not touched.
- R6: The scan index advances once every `SCAN_DIV` clocks. It wraps from the last active digit (or from any higher index) to 0, and `scan_o` shows it in binary.
- R7: `out_a_o` carries bits 7:4 and `out_b_o` carries bits 3:0 of the byte at the current scan index.
- R8: `blank_a_i`=1 replaces `out_a_o` with `blank_code_i`, and `blank_b_i`=1 replaces `out_b_o` with it. The two controls act independently, and neither one changes the stored data.
- R9: `bd_o` is 1 for exactly the first clock after each scan index change and is 0 at all other times.
- R10: When `ptr_load_i` and `wr_i` are both high in the same cycle, the load takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bit 0: 16 digits; bit 1: right entry |
| ptr_load_i | input | 1 | Load the write position from addr_i |
| addr_i | input | 4 | Position to load |
| wr_i | input | 1 | Write one byte |
| wr_data_i | input | 8 | Byte to write |
| auto_inc_i | input | 1 | Step the position after a left-entry write |
| blank_a_i | input | 1 | Blank output group A |
| blank_b_i | input | 1 | Blank output group B |
| blank_code_i | input | 4 | Value driven on a blanked group |
| scan_o | output | 4 | Current digit index |
| out_a_o | output | 4 | High half of the current digit's byte |
| out_b_o | output | 4 | Low half of the current digit's byte |
| bd_o | output | 1 | Blank-display strobe at each digit change |

## Verification
A write, a pointer load and a scan step all act at the clock edge where they are sampled. Their effect therefore appears on the outputs in that same cycle after the edge. `bd_o` is registered and rises in the first cycle of the new digit. The blank controls act combinationally, with no clock between them and the outputs. The bench drives inputs 1 ns after a rising edge and updates its behavioural model on the rising edge. It compares `scan_o`, both output groups and `bd_o` against the model at every falling edge, so each result is checked in the cycle it becomes due. Directed checks also wait for a chosen scan index and compare fixed literal values.

// File: rtl/disp_pkg.sv
package disp_pkg;
  parameter int DIGITS = 16;
  localparam int AW = $clog2(DIGITS);
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef logic [AW-1:0] idx_t;
  typedef logic [DW-1:0] byte_t;
  typedef logic [NW-1:0] nib_t;

  // mode_i[1] = right entry, mode_i[0] = all digits active
  typedef struct packed {
    logic right;
    logic wide;
  } dmode_t;

  function automatic idx_t last_idx(input logic wide);
    return wide ? idx_t'(DIGITS - 1) : idx_t'(DIGITS / 2 - 1);
  endfunction

  function automatic idx_t step_idx(input idx_t cur, input logic wide);
    return (cur >= last_idx(wide)) ? '0 : idx_t'(cur + 1'b1);
  endfunction
endpackage

// File: rtl/disp_ram.sv
module disp_ram
  import disp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  dmode_t mode,
  input  logic   load_i,
  input  idx_t   addr_i,
  input  logic   wr_i,
  input  logic   auto_inc_i,
  input  byte_t  data_i,
  input  idx_t   rd_idx_i,
  output byte_t  rd_data_o
);
  byte_t mem [DIGITS];
  idx_t  ptr_q;
  idx_t  last;
  logic  wr_left;
  logic  wr_right;

  assign last      = last_idx(mode.wide);
  assign wr_left   = wr_i && !load_i && !mode.right;
  assign wr_right  = wr_i && !load_i && mode.right;
  assign rd_data_o = mem[rd_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DIGITS; i++) mem[i] <= '0;
    end else begin
      if (load_i) ptr_q <= addr_i;
      else if (wr_left && auto_inc_i) ptr_q <= step_idx(ptr_q, mode.wide);
      if (wr_left) mem[ptr_q] <= data_i;
      if (wr_right) begin
        for (int i = 0; i < DIGITS; i++) begin
          if (i < int'(last)) mem[i] <= mem[(i + 1) % DIGITS];
          else if (i == int'(last)) mem[i] <= data_i;
        end
      end
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ptr_q == $past(addr_i));
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_left && auto_inc_i && ptr_q == last) |=> ptr_q == '0);
  p_right_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_right |=> $stable(ptr_q));
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_pkg::*;
#(
  parameter int SCAN_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide,
  output idx_t digit_o,
  output logic bd_o
);
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  logic [CW-1:0] cnt_q;
  idx_t digit_q;
  logic bd_q;
  logic step;

  assign step    = (cnt_q == CW'(SCAN_DIV - 1));
  assign digit_o = digit_q;
  assign bd_o    = bd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      digit_q <= '0;
      bd_q    <= 1'b0;
    end else begin
      cnt_q   <= step ? '0 : cnt_q + 1'b1;
      bd_q    <= step;
      if (step) digit_q <= step_idx(digit_q, wide);
    end
  end

  p_scan_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && digit_q == last_idx(wide)) |=> digit_q == '0);
  p_bd_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digit_q) |-> bd_q);
  p_bd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bd_q |=> !bd_q);
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh
  import disp_pkg::*;
#(
  parameter int SCAN_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       ptr_load_i,
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       auto_inc_i,
  input  logic       blank_a_i,
  input  logic       blank_b_i,
  input  logic [3:0] blank_code_i,
  output logic [3:0] scan_o,
  output logic [3:0] out_a_o,
  output logic [3:0] out_b_o,
  output logic       bd_o
);
  dmode_t mode;
  idx_t   digit;
  byte_t  cur_byte;

  assign mode = dmode_t'(mode_i);

  disp_ram u_ram (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load_i(ptr_load_i),
    .addr_i(idx_t'(addr_i)), .wr_i(wr_i), .auto_inc_i(auto_inc_i),
    .data_i(byte_t'(wr_data_i)), .rd_idx_i(digit), .rd_data_o(cur_byte)
  );

  disp_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
    .clk(clk), .rst_n(rst_n), .wide(mode.wide), .digit_o(digit), .bd_o(bd_o)
  );

  assign scan_o  = 4'(digit);
  assign out_a_o = blank_a_i ? blank_code_i : cur_byte[DW-1:NW];
  assign out_b_o = blank_b_i ? blank_code_i : cur_byte[NW-1:0];

  p_reset_bd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bd_o && scan_o == 4'd0));
endmodule

// File: tb/disp_refresh_bench.sv
`timescale 1ns/1ps
module disp_refresh_bench;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b01;
  logic ld = 0, wr = 0, inc = 0, ba = 0, bb = 0;
  logic [3:0] addr = 0, code = 0;
  logic [7:0] data = 0;
  logic [3:0] scan_o, out_a_o, out_b_o;
  logic bd_o;
  int total = 0, fails = 0;
  bit done = 0;

  int m [16];
  int ptr = 0, cnt = 0, dig = 0, mbd = 0;

  always #2.5 clk = ~clk;

  disp_refresh #(.SCAN_DIV(DIV)) u_disp_refresh (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ptr_load_i(ld), .addr_i(addr),
    .wr_i(wr), .wr_data_i(data), .auto_inc_i(inc), .blank_a_i(ba),
    .blank_b_i(bb), .blank_code_i(code), .scan_o(scan_o), .out_a_o(out_a_o),
    .out_b_o(out_b_o), .bd_o(bd_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    int last;
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      ptr = 0; cnt = 0; dig = 0; mbd = 0;
    end else begin
      last = mode[0] ? 15 : 7;
      if (ld) ptr = addr;
      else if (wr) begin
        if (mode[1]) begin
          for (int i = 0; i < last; i++) m[i] = m[i+1];
          m[last] = data;
        end else begin
          m[ptr] = data;
          if (inc) ptr = (ptr >= last) ? 0 : ptr + 1;
        end
      end
      if (cnt == DIV - 1) begin
        cnt = 0; dig = (dig >= last) ? 0 : dig + 1; mbd = 1;
      end else begin
        cnt++; mbd = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int ea, eb;
    ea = ba ? int'(code) : (m[dig] >> 4) & 15;
    eb = bb ? int'(code) : m[dig] & 15;
    chk(scan_o == dig, "R6 scan", scan_o, dig);
    chk(out_a_o == ea, "R7/R8 group A", out_a_o, ea);
    chk(out_b_o == eb, "R7/R8 group B", out_b_o, eb);
    chk(bd_o == mbd, "R9 bd", bd_o, mbd);
  end

  task automatic go(); @(posedge clk); #1; endtask
  task automatic load(input int a); go(); ld = 1; addr = 4'(a); go(); ld = 0; endtask
  task automatic put(input int d); go(); wr = 1; data = 8'(d); go(); wr = 0; endtask
  task automatic idle(input int n); repeat (n) go(); endtask
  task automatic wait_digit(input int d);
    do @(negedge clk); while (scan_o != 4'(d));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(scan_o == 0 && bd_o == 0, "R1 reset scan/bd", {scan_o, 3'b0, bd_o}, 0);
    chk(out_a_o == 0 && out_b_o == 0, "R1 reset outputs", {out_a_o, out_b_o}, 0);
    go(); rst_n = 1;
    idle(10);
    // R2/R3: 16-digit left entry, auto increment
    mode = 2'b01; inc = 1;
    load(0);
    for (int i = 0; i < 16; i++) put(i * 16 + (15 - i));
    put(8'hC3);                 // R3 wrap to digit 0
    wait_digit(5);
    chk(out_a_o == 5 && out_b_o == 10, "R2 digit5 literal", {out_a_o, out_b_o}, 8'h5A);
    wait_digit(0);
    chk(out_a_o == 4'hC && out_b_o == 4'h3, "R3 wrap literal", {out_a_o, out_b_o}, 8'hC3);
    // R4: no increment, same digit overwritten
    inc = 0; load(9); put(8'h11); put(8'h22);
    wait_digit(9);
    chk(out_a_o == 2 && out_b_o == 2, "R4 overwrite literal", {out_a_o, out_b_o}, 8'h22);
    // R10: load with write in same cycle
    go(); ld = 1; wr = 1; addr = 4'd3; data = 8'hEE; go(); ld = 0; wr = 0;
    put(8'h77);
    wait_digit(3);
    chk(out_a_o == 7 && out_b_o == 7, "R10 load wins", {out_a_o, out_b_o}, 8'h77);
    // R3 in 8-digit mode, start above last
    mode = 2'b00; inc = 1; load(12); put(8'h44); put(8'h55);
    idle(70);
    // R5: right entry, 8 digits
    mode = 2'b10; put(8'h13); put(8'h26); put(8'h39);
    wait_digit(7);
    chk(out_a_o == 3 && out_b_o == 9, "R5 newest at right", {out_a_o, out_b_o}, 8'h39);
    wait_digit(6);
    chk(out_a_o == 2 && out_b_o == 6, "R5 shifted left", {out_a_o, out_b_o}, 8'h26);
    // R5: right entry, 16 digits
    mode = 2'b11; put(8'hA5); put(8'h5A);
    idle(80);
    // R8: independent blanking
    code = 4'hF; ba = 1; idle(40);
    wait_digit(15);
    chk(out_a_o == 4'hF && out_b_o == 4'hA, "R8 A blanked only", {out_a_o, out_b_o}, 8'hFA);
    ba = 0; bb = 1; code = 4'h6; idle(40);
    bb = 0; ba = 1; bb = 1; code = 4'h0; idle(20);
    ba = 0; bb = 0; idle(70);
    mode = 2'b01; idle(80);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule